// File: doc/BRIEF.md
# SRAM Bank Capture Controller

This block takes a 32-bit sample stream and lays it down in a bank of eight 16-bit asynchronous SRAM chips. The chips share one word address, one active-low write strobe and one active-low output enable. Each chip has its own active-low select. Incoming samples are gathered four at a time into a 128-bit word. Sixteen bits of that word go to each chip, and one strobe stores all eight slices at a single address. The storage rate is therefore a quarter of the sample rate.

Each pass begins with a start pulse, which latches the operation and a 4-bit depth code. In a write pass, every packed word becomes one bank write, at addresses 0, 1, 2 and so on. In a read pass, the chips are visited one after another, lowest chip first, and each chip's 16-bit word is returned on a narrow readback port. An internal access counter ends the pass at a length set by the depth code. It then raises a halt flag and pulses a done flag.

Top module: `sram_bank_capture`

## Requirements
- R1: After reset, and while no pass is running, both strobes and every chip select sit at 1, `cnt_halt` is 1, and `pass_done` and `rd_valid` are 0.
- R2: Four accepted samples (those with `smp_valid`=1) form one 128-bit word. The first sample goes to bits 31:0 and the fourth to bits 127:96. Bits 16k+15:16k drive chip k.
- R3: In a write pass (mode 0), each packed word produces exactly one cycle with `sram_we_n`=0 and every `sram_cs_n` bit at 0. The address of the n-th word of the pass is n, counting from 0.
- R4: In a read pass (mode 1), access j drives `sram_oe_n`=0 and word address j/8. Only select bit j mod 8 is 0, so 11011111 selects chip 5, the sixth chip.
- R5: One cycle after a read access, `rd_valid` is 1 and `rd_data` holds the 16 bits that the selected chip returned.
- R6: A pass holds 8·2^d accesses, where d is the depth code, capped at 2^ADDR_W. With d=0 the pass is 8 accesses: the first word of every chip.
- R7: Once the count is reached, `cnt_halt` goes to 1 and both strobes stay inactive. Packed words that arrive while halted are dropped and are never written.
- R8: `start` clears the count and the halt flag and latches `mode` and `depth`. Changes on `mode` or `depth` during a pass have no effect on that pass.
- R9: `pass_done` is 1 for exactly one cycle: the cycle after the last access of a pass, with `cnt_halt` already 1.
- R10: The write and read strobes are never both 0. A read pass never writes, and a write pass never reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass, latching mode and depth |
| mode | input | 1 | 0 = write pass, 1 = read pass |
| depth | input | 4 | Pass length code d, length 8·2^d |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 32 | Sample word |
| sram_addr | output | 18 | Shared word address |
| sram_we_n | output | 1 | Shared write strobe, active low |
| sram_oe_n | output | 1 | Shared output enable, active low |
| sram_cs_n | output | 8 | Per-chip select, active low, bit k = chip k |
| sram_wdata | output | 128 | Write data, bits 16k+15:16k to chip k |
| sram_rdata | input | 128 | Chip data lines, bits 16k+15:16k from chip k |
| rd_data | output | 16 | Readback word |
| rd_valid | output | 1 | Readback qualifier |
| cnt_halt | output | 1 | Count-enable flag, 1 when halted |
| pass_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The main instance is built with the default values: 32-bit samples packed by four, eight 16-bit chips and an 18-bit address. These defaults exercise write passes of 32 words, including extra words that must be dropped, read passes at depth codes 0, 1 and 2, and a change of the pass inputs partway through a pass. A second instance uses a 5-bit address, so a large depth code hits the cap after 32 accesses while a small code stays below it.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_mode_e;
endpackage

// File: rtl/sbc_packer.sv
// Gathers PACK_N samples into one wide word; first sample lands lowest.
module sbc_packer #(
  parameter int SAMPLE_W = 32,
  parameter int PACK_N   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         in_valid,
  input  logic [SAMPLE_W-1:0]          in_data,
  output logic                         word_valid,
  output logic [SAMPLE_W*PACK_N-1:0]   word_data
);
  localparam int PH_W   = $clog2(PACK_N);
  localparam int WORD_W = SAMPLE_W * PACK_N;

  logic [PACK_N-2:0][SAMPLE_W-1:0] hold_q, hold_d;
  logic [PH_W-1:0]                 ph_q, ph_d;
  logic                            wv_q, wv_d;
  logic [WORD_W-1:0]               word_q, word_d;

  always_comb begin
    hold_d = hold_q;
    ph_d   = ph_q;
    wv_d   = 1'b0;
    word_d = word_q;
    if (clear) begin
      ph_d = '0;
    end else if (in_valid) begin
      if (ph_q == PH_W'(PACK_N - 1)) begin
        for (int i = 0; i < PACK_N - 1; i++) begin
          word_d[i*SAMPLE_W +: SAMPLE_W] = hold_q[i];
        end
        word_d[(PACK_N-1)*SAMPLE_W +: SAMPLE_W] = in_data;
        wv_d = 1'b1;
        ph_d = '0;
      end else begin
        hold_d[ph_q] = in_data;
        ph_d         = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ph_q   <= '0;
      wv_q   <= 1'b0;
      word_q <= '0;
    end else begin
      hold_q <= hold_d;
      ph_q   <= ph_d;
      wv_q   <= wv_d;
      word_q <= word_d;
    end
  end

  assign word_valid = wv_q;
  assign word_data  = word_q;

  // R2: a packed word needs several samples, so two never come back to back
  p_word_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
endmodule

// File: rtl/sbc_pass_ctrl.sv
// Access counter with depth limit, halt (count-enable) flag and done pulse.
module sbc_pass_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DEPTH_W = 4,
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  op_mode_e           mode_in,
  input  logic [DEPTH_W-1:0] depth_in,
  input  logic               step,
  output op_mode_e           mode_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               halt_q,
  output logic               done_q
);
  op_mode_e           mode_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic [CNT_W-1:0]   cnt_d, cnt_inc, limit;
  logic               halt_d, done_d;

  always_comb begin
    if (int'(depth_q) + 3 >= ADDR_W) limit = CNT_W'(1) << ADDR_W;
    else                             limit = CNT_W'(8) << depth_q;
  end

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    mode_d  = mode_q;
    depth_d = depth_q;
    cnt_d   = cnt_q;
    halt_d  = halt_q;
    done_d  = 1'b0;
    if (start) begin
      mode_d  = mode_in;
      depth_d = depth_in;
      cnt_d   = '0;
      halt_d  = 1'b0;
    end else if (step && !halt_q) begin
      cnt_d = cnt_inc;
      if (cnt_inc == limit) begin
        halt_d = 1'b1;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= OP_WRITE;
      depth_q <= '0;
      cnt_q   <= '0;
      halt_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      depth_q <= depth_d;
      cnt_q   <= cnt_d;
      halt_q  <= halt_d;
      done_q  <= done_d;
    end
  end

  // R6: the count never runs past the pass length
  p_count_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
  // R7: a halted counter holds until the next start
  p_halt_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !start) |=> $stable(cnt_q) && halt_q);
  // R8: start reopens the pass from zero
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0) && !halt_q);
  // R9: done pulse is single and only with the halt flag up
  p_done_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> halt_q);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/sbc_strobe_dec.sv
// Address, strobe and chip-select generation plus readback selection.
module sbc_strobe_dec
  import sbc_pkg::*;
#(
  parameter int CHIPS   = 8,
  parameter int CHIP_DW = 16,
  parameter int ADDR_W  = 18,
  localparam int CNT_W  = ADDR_W + 1,
  localparam int SEL_W  = $clog2(CHIPS),
  localparam int BUS_W  = CHIPS * CHIP_DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  op_mode_e           mode_q,
  input  logic               halt_q,
  input  logic               word_valid,
  input  logic [CNT_W-1:0]   cnt_q,
  input  logic [BUS_W-1:0]   word_data,
  input  logic [BUS_W-1:0]   rdata,
  output logic [ADDR_W-1:0]  addr,
  output logic               we_n,
  output logic               oe_n,
  output logic [CHIPS-1:0]   cs_n,
  output logic [BUS_W-1:0]   wdata,
  output logic [CHIP_DW-1:0] sel_data
);
  logic             wr_act, rd_act;
  logic [SEL_W-1:0] chip;

  assign wr_act = !halt_q && (mode_q == OP_WRITE) && word_valid;
  assign rd_act = !halt_q && (mode_q == OP_READ);
  assign chip   = cnt_q[SEL_W-1:0];

  always_comb begin
    if (mode_q == OP_READ) addr = ADDR_W'(cnt_q >> SEL_W);
    else                   addr = cnt_q[ADDR_W-1:0];
  end

  assign we_n  = !wr_act;
  assign oe_n  = !rd_act;
  assign wdata = word_data;

  for (genvar k = 0; k < CHIPS; k++) begin : g_sel
    assign cs_n[k] = !(wr_act || (rd_act && (chip == SEL_W'(k))));
  end

  assign sel_data = rdata[chip*CHIP_DW +: CHIP_DW];

  // R3: a bank write reaches every chip
  p_write_all_chips_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (cs_n == '0));
  // R4: a read touches exactly one chip
  p_single_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> $onehot(~cs_n));
  // R10: never drive and read the shared bus together
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  // R1: without a strobe no chip is selected
  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n) |-> (&cs_n));
endmodule

// File: rtl/sram_bank_capture.sv
module sram_bank_capture
  import sbc_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int PACK_N   = 4,
  parameter int CHIPS    = 8,
  parameter int CHIP_DW  = 16,
  parameter int ADDR_W   = 18,
  parameter int DEPTH_W  = 4,
  localparam int BUS_W   = CHIPS * CHIP_DW,
  localparam int CNT_W   = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                mode,
  input  logic [DEPTH_W-1:0]  depth,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic                sram_we_n,
  output logic                sram_oe_n,
  output logic [CHIPS-1:0]    sram_cs_n,
  output logic [BUS_W-1:0]    sram_wdata,
  input  logic [BUS_W-1:0]    sram_rdata,
  output logic [CHIP_DW-1:0]  rd_data,
  output logic                rd_valid,
  output logic                cnt_halt,
  output logic                pass_done
);
  // SAMPLE_W * PACK_N is expected to equal CHIPS * CHIP_DW
  logic               word_valid;
  logic [BUS_W-1:0]   word_data;
  op_mode_e           mode_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               halt_q, step;
  logic [CHIP_DW-1:0] sel_data, rdd_q, rdd_d;
  logic               rdv_q, rdv_d;

  sbc_packer #(.SAMPLE_W(SAMPLE_W), .PACK_N(PACK_N)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .in_valid(smp_valid), .in_data(smp_data),
    .word_valid(word_valid), .word_data(word_data));

  assign step = (mode_q == OP_READ) || word_valid;

  sbc_pass_ctrl #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mode_in(op_mode_e'(mode)), .depth_in(depth), .step(step),
    .mode_q(mode_q), .cnt_q(cnt_q), .halt_q(halt_q), .done_q(pass_done));

  sbc_strobe_dec #(.CHIPS(CHIPS), .CHIP_DW(CHIP_DW), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .halt_q(halt_q),
    .word_valid(word_valid), .cnt_q(cnt_q), .word_data(word_data),
    .rdata(sram_rdata), .addr(sram_addr), .we_n(sram_we_n),
    .oe_n(sram_oe_n), .cs_n(sram_cs_n), .wdata(sram_wdata),
    .sel_data(sel_data));

  always_comb begin
    rdv_d = !sram_oe_n;
    rdd_d = rdd_q;
    if (!sram_oe_n) rdd_d = sel_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      rdv_q <= rdv_d;
      rdd_q <= rdd_d;
    end
  end

  assign rd_data  = rdd_q;
  assign rd_valid = rdv_q;
  assign cnt_halt = halt_q;

  // R5: readback follows a read access by one cycle
  p_readback_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |=> rd_valid);
  // R7: no strobe while halted
  p_quiet_when_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_halt |-> (sram_we_n && sram_oe_n));
endmodule

// File: tb/sram_bank_capture_test.sv
module sram_bank_capture_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         start = 0, mode = 0, smp_valid = 0;
  logic [3:0]   depth = 0;
  logic [31:0]  smp_data = 0;
  logic [17:0]  sram_addr;
  logic         sram_we_n, sram_oe_n, rd_valid, cnt_halt, pass_done;
  logic [7:0]   sram_cs_n;
  logic [127:0] sram_wdata, sram_rdata;
  logic [15:0]  rd_data;

  sram_bank_capture uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .depth(depth),
    .smp_valid(smp_valid), .smp_data(smp_data), .sram_addr(sram_addr),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_cs_n(sram_cs_n),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .cnt_halt(cnt_halt), .pass_done(pass_done));

  // second build: 5-bit address so the depth cap is reachable
  logic         start_c = 0;
  logic [3:0]   depth_c = 0;
  logic [4:0]   addr_c;
  logic         we_c, oe_c, rdv_c, halt_c, done_c;
  logic [7:0]   cs_c;
  logic [127:0] wd_c;
  logic [15:0]  rdd_c;

  sram_bank_capture #(.ADDR_W(5)) uut_cap (
    .clk(clk), .rst_n(rst_n), .start(start_c), .mode(1'b1), .depth(depth_c),
    .smp_valid(1'b0), .smp_data(32'h0), .sram_addr(addr_c),
    .sram_we_n(we_c), .sram_oe_n(oe_c), .sram_cs_n(cs_c),
    .sram_wdata(wd_c), .sram_rdata(128'h0), .rd_data(rdd_c),
    .rd_valid(rdv_c), .cnt_halt(halt_c), .pass_done(done_c));

  // simple cycle-based SRAM bank model
  logic [15:0] mem [0:7][0:63];
  always @(posedge clk) begin
    for (int k = 0; k < 8; k++)
      if (!sram_we_n && !sram_cs_n[k]) mem[k][sram_addr[5:0]] <= sram_wdata[k*16 +: 16];
  end
  always_comb begin
    for (int k = 0; k < 8; k++)
      sram_rdata[k*16 +: 16] = (!sram_oe_n && !sram_cs_n[k]) ? mem[k][sram_addr[5:0]] : 16'h0;
  end

  int n_chk = 0, n_err = 0;
  int cyc = 0, last_acc = 0;
  int wr_idx = 0, acc = 0, rdi = 0, done_cnt = 0, limit_exp = 0;
  bit pass_read = 0;
  logic [127:0] exp_words [0:63];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sel_pattern(input int chip);
    return ~(8'b1 << chip);
  endfunction

  function automatic logic [15:0] exp_slice(input int j);
    return exp_words[j / 8][(j % 8) * 16 +: 16];
  endfunction

  // monitor: samples outputs at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!sram_we_n) begin
        chk(!pass_read, "R10 write strobe in read pass", 0, 1);
        chk(wr_idx < limit_exp, "R7 write after limit", wr_idx, limit_exp);
        chk(sram_cs_n == 8'h00, "R3 all selects low", sram_cs_n, 0);
        chk(sram_addr == 18'(wr_idx), "R3 write address", sram_addr, wr_idx);
        if (wr_idx < 64)
          chk(sram_wdata == exp_words[wr_idx], "R2 packed word", sram_wdata, exp_words[wr_idx]);
        wr_idx++;
        last_acc = cyc;
      end
      if (!sram_oe_n) begin
        chk(pass_read && sram_we_n, "R10 read strobe in write pass", 0, 1);
        chk(acc < limit_exp, "R7 read after limit", acc, limit_exp);
        chk(sram_cs_n == sel_pattern(acc % 8), "R4 chip select", sram_cs_n, sel_pattern(acc % 8));
        chk(sram_addr == 18'(acc / 8), "R4 read address", sram_addr, acc / 8);
        acc++;
        last_acc = cyc;
      end
      if (rd_valid) begin
        chk(rd_data == exp_slice(rdi), "R5 readback data", rd_data, exp_slice(rdi));
        rdi++;
      end
      if (pass_done) begin
        done_cnt++;
        chk(cnt_halt, "R9 halt with done", cnt_halt, 1);
        chk(last_acc == cyc - 1, "R9 done timing", cyc - last_acc, 1);
      end
    end
  end

  task automatic begin_pass(input bit rd, input logic [3:0] d, input int lim);
    @(negedge clk);
    start = 1; mode = rd; depth = d;
    pass_read = rd; limit_exp = lim; wr_idx = 0; acc = 0; rdi = 0; done_cnt = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic send_words(input int n, input bool_rec);
    for (int w = 0; w < n; w++) begin
      for (int s = 0; s < 4; s++) begin
        int gap;
        gap = $urandom_range(0, 2);
        for (int g = 0; g < gap; g++) begin
          smp_valid = 0;
          @(negedge clk);
        end
        smp_valid = 1;
        smp_data = $urandom;
        if (bool_rec != 0 && w < 64) exp_words[w][s*32 +: 32] = smp_data;
        @(negedge clk);
      end
    end
    smp_valid = 0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cap_run(input logic [3:0] d, input int expect_cycles);
    int n;
    @(negedge clk);
    start_c = 1; depth_c = d;
    @(negedge clk);
    start_c = 0;
    n = 1;
    while (!done_c && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == expect_cycles, "R6 capped pass length", n, expect_cycles);
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(20081109);
    for (int i = 0; i < 64; i++) exp_words[i] = '0;
    settle(3);
    rst_n = 1;
    settle(1);
    // R1 reset state
    chk(sram_we_n && sram_oe_n, "R1 strobes idle", {sram_we_n, sram_oe_n}, 2'b11);
    chk(sram_cs_n == 8'hFF, "R1 selects idle", sram_cs_n, 8'hFF);
    chk(cnt_halt && !pass_done && !rd_valid, "R1 flags", {cnt_halt, pass_done, rd_valid}, 3'b100);

    // samples with no pass open must not write (limit 0)
    send_words(3, 0);
    settle(3);
    chk(wr_idx == 0, "R1 no write while idle", wr_idx, 0);

    // write pass, depth 2 => 32 words; 4 extra words dropped
    begin_pass(0, 4'd2, 32);
    mode = 1; depth = 4'd0;   // R8 ignored mid-pass
    send_words(36, 1);
    settle(4);
    chk(wr_idx == 32, "R7 write count stops at limit", wr_idx, 32);
    chk(done_cnt == 1, "R9 single done in write pass", done_cnt, 1);
    chk(cnt_halt, "R7 halted after write pass", cnt_halt, 1);

    // read pass depth 0 => first word of each chip
    begin_pass(1, 4'd0, 8);
    settle(12);
    chk(acc == 8 && rdi == 8, "R6 depth 0 read length", acc, 8);
    chk(done_cnt == 1, "R9 done depth 0", done_cnt, 1);

    // read pass depth 1, inputs changed mid pass
    begin_pass(1, 4'd1, 16);
    mode = 0; depth = 4'd3;
    settle(22);
    chk(acc == 16 && rdi == 16, "R8 depth 1 read length", acc, 16);

    // read pass depth 2 => 32 accesses
    begin_pass(1, 4'd2, 32);
    settle(38);
    chk(acc == 32 && rdi == 32, "R6 depth 2 read length", acc, 32);
    chk(done_cnt == 1, "R9 done depth 2", done_cnt, 1);

    // second write pass with fresh random data, then read it back
    begin_pass(0, 4'd1, 16);
    send_words(16, 1);
    settle(4);
    chk(wr_idx == 16, "R3 depth 1 write count", wr_idx, 16);
    begin_pass(1, 4'd1, 16);
    settle(22);
    chk(rdi == 16, "R5 readback after rewrite", rdi, 16);

    // cap: 5-bit address instance; depth 3 => 64 capped to 32, depth 1 => 16
    cap_run(4'd3, 33);
    cap_run(4'd1, 17);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule